// File: doc/BRIEF.md
# Branch Delay Slot Sequencer

This block is the front-end control of a simple in-order core. Each cycle it presents the program counter of the instruction at the issue point. For that instruction it decides whether it executes, is annulled, or raises an exception. After a branch, a fixed number of delay slots follows, set by a parameter from one to three. The first slot always runs. Any later slot runs only if the branch was taken. When the slots end, fetch moves to the branch target or falls through.

A runtime enable turns the slot behaviour on or off. The sequencer samples the enable when the branch issues. With the enable low, a taken branch redirects fetch at once and no slot follows. A fault on an instruction that would execute stops that instruction and sends fetch to a fixed vector. The fault may come from the fetch of the instruction or from its execution. At that point the sequencer records the faulting PC, the slot position, and the branch direction and target. A return-from-exception restores that context, so the faulting slot runs again and the rest of the sequence completes before the jump.

Top module: `bds_sequencer`

## Requirements
- R1: After reset, `fetch_pc` equals RESET_PC (0x100 by default), `slot_idx` is 0, `in_handler` is 0 and every saved-context output is 0.
- R2: A valid non-branch instruction outside any slot drives `exec_ok` high, and the next `fetch_pc` is the current one plus 4. A cycle with `inst_valid` low drives neither `exec_ok` nor `annul` and leaves `fetch_pc` unchanged.
- R3: A branch issued with `ds_enable` high executes. The next NSLOT issued instructions report `slot_idx` 1, 2, … NSLOT in order at consecutive PCs (0 means not in a slot). Slot 1 always executes, whether or not the branch is taken, so with NSLOT=1 an untaken branch simply falls through.
- R4: Slots 2..NSLOT execute when the branch was taken and are annulled (`annul` high, `exec_ok` low) when it was not. `exec_ok` and `annul` are never both high.
- R5: After the last slot, `fetch_pc` becomes the branch target if the branch was taken, and otherwise the last slot's PC plus 4.
- R6: A branch issued with `ds_enable` low opens no slot. If taken, the next `fetch_pc` is its target. If not taken, it is PC plus 4. Changing `ds_enable` while slots are in progress has no effect on them.
- R7: A branch that arrives in a delay slot raises `illegal_br`, is annulled, and does not redirect fetch. The slot sequence then continues as if the branch were absent.
- R8: A fetch fault or execution fault on an instruction that would execute (outside the handler) raises `exc_take` and suppresses `exec_ok`. The next `fetch_pc` is EXC_VEC (0x80 by default) and `in_handler` goes high. From the next cycle, `sv_pc`, `sv_idx`, `sv_taken` and `sv_target` hold the faulting PC, its slot index, and the open branch's direction and target. Direction and target read 0 when the index is 0.
- R9: A fault on an annulled slot raises no exception, and the slot is still annulled. A fault on any instruction while `in_handler` is high is ignored, and the instruction executes.
- R10: An instruction marked `eret` while `in_handler` is high executes. It clears `in_handler`, sets the next `fetch_pc` to `sv_pc` and `slot_idx` to `sv_idx`, and restores the branch direction and target. The faulting slot then re-runs, the remaining slots follow, and fetch jumps as in R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inst_valid | input | 1 | An instruction token is at the issue point this cycle |
| br_dec | input | 1 | The token is a branch |
| br_taken | input | 1 | Branch resolves taken |
| br_target | input | AW | Branch target address |
| ds_enable | input | 1 | Runtime delay-slot enable, sampled at branch issue |
| fault_fetch | input | 1 | The fetch of this token faulted |
| fault_exec | input | 1 | The execution of this token faulted |
| eret | input | 1 | The token is a return from exception |
| fetch_pc | output | AW | PC of the token at the issue point |
| slot_idx | output | 2 | Slot position of the token, 0 outside slots |
| exec_ok | output | 1 | The token executes |
| annul | output | 1 | The token is annulled |
| illegal_br | output | 1 | A branch was found inside a delay slot |
| exc_take | output | 1 | An exception is taken on this token |
| in_handler | output | 1 | The exception handler is running |
| sv_pc | output | AW | Saved faulting PC |
| sv_idx | output | 2 | Saved slot index |
| sv_taken | output | 1 | Saved branch direction |
| sv_target | output | AW | Saved branch target |

## Verification
The hardest state to reach is a resume into the middle of a slot sequence. The sequencer has to come back from the handler at slot 2 of a taken branch, finish slot 3, and still jump to the saved target. The bench gets there by issuing a taken branch and letting slot 1 complete. It then faults slot 2 and runs one handler instruction that carries a fault of its own, which must be ignored. An `eret` follows, and the bench tracks every later PC and slot index up to the target. A second pass does the same with an untaken branch. There, slot 1 faults at fetch, and after the resume a fault on the annulled slot 2 must not be taken.

// File: rtl/bds_pkg.sv
package bds_pkg;

  localparam int SLOT_W = 2;

  typedef logic [SLOT_W-1:0] slot_t;

  typedef enum logic [2:0] {
    NX_HOLD   = 3'd0,
    NX_SEQ    = 3'd1,
    NX_VEC    = 3'd2,
    NX_RESUME = 3'd3,
    NX_JUMP   = 3'd4
  } nx_sel_e;

  // Index 0 means "not in a slot" and always runs; slot 1 always runs;
  // later slots run only behind a taken branch.
  function automatic logic slot_runs(input slot_t idx, input logic taken);
    return (idx <= slot_t'(1)) || taken;
  endfunction

  function automatic slot_t slot_step(input slot_t idx, input slot_t last_idx);
    return (idx == last_idx) ? slot_t'(0) : slot_t'(idx + slot_t'(1));
  endfunction

endpackage

// File: rtl/bds_pc_gen.sv
module bds_pc_gen
  import bds_pkg::*;
#(
  parameter int            AW       = 32,
  parameter logic [AW-1:0] RESET_PC = 'h100,
  parameter logic [AW-1:0] EXC_VEC  = 'h80,
  parameter int            STEP     = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  nx_sel_e       sel,
  input  logic [AW-1:0] resume_pc,
  input  logic [AW-1:0] jump_pc,
  output logic [AW-1:0] pc
);

  function automatic logic [AW-1:0] seq_pc(input logic [AW-1:0] cur);
    return cur + AW'(STEP);
  endfunction

  logic [AW-1:0] pc_next;

  always_comb begin
    unique case (sel)
      NX_SEQ:    pc_next = seq_pc(pc);
      NX_VEC:    pc_next = EXC_VEC;
      NX_RESUME: pc_next = resume_pc;
      NX_JUMP:   pc_next = jump_pc;
      default:   pc_next = pc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pc <= RESET_PC;
    else        pc <= pc_next;
  end

endmodule

// File: rtl/bds_slot_tracker.sv
module bds_slot_tracker
  import bds_pkg::*;
#(
  parameter int AW    = 32,
  parameter int NSLOT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          start,
  input  logic          start_taken,
  input  logic [AW-1:0] start_target,
  input  logic          flush,
  input  logic          restore,
  input  slot_t         rs_idx,
  input  logic          rs_taken,
  input  logic [AW-1:0] rs_target,
  output slot_t         idx,
  output logic          taken,
  output logic [AW-1:0] target,
  output logic          last
);

  localparam slot_t LAST_IDX = slot_t'(NSLOT);

  assign last = (idx == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx    <= '0;
      taken  <= 1'b0;
      target <= '0;
    end else if (restore) begin
      idx    <= rs_idx;
      taken  <= rs_taken;
      target <= rs_target;
    end else if (flush) begin
      idx    <= '0;
      taken  <= 1'b0;
      target <= '0;
    end else if (start) begin
      idx    <= slot_t'(1);
      taken  <= start_taken;
      target <= start_target;
    end else if (adv && idx != '0) begin
      idx <= slot_step(idx, LAST_IDX);
      if (last) begin
        taken  <= 1'b0;
        target <= '0;
      end
    end
  end

endmodule

// File: rtl/bds_exc_ctx.sv
module bds_exc_ctx
  import bds_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap,
  input  logic          release_ctx,
  input  logic [AW-1:0] cap_pc,
  input  slot_t         cap_idx,
  input  logic          cap_taken,
  input  logic [AW-1:0] cap_target,
  output logic          busy,
  output logic [AW-1:0] sv_pc,
  output slot_t         sv_idx,
  output logic          sv_taken,
  output logic [AW-1:0] sv_target
);

  logic open_slot;
  assign open_slot = (cap_idx != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      sv_pc     <= '0;
      sv_idx    <= '0;
      sv_taken  <= 1'b0;
      sv_target <= '0;
    end else if (cap) begin
      busy      <= 1'b1;
      sv_pc     <= cap_pc;
      sv_idx    <= cap_idx;
      sv_taken  <= open_slot & cap_taken;
      sv_target <= open_slot ? cap_target : '0;
    end else if (release_ctx) begin
      busy <= 1'b0;
    end
  end

endmodule

// File: rtl/bds_sequencer.sv
module bds_sequencer
  import bds_pkg::*;
#(
  parameter int            AW       = 32,
  parameter int            NSLOT    = 3,
  parameter logic [AW-1:0] RESET_PC = 'h100,
  parameter logic [AW-1:0] EXC_VEC  = 'h80
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inst_valid,
  input  logic          br_dec,
  input  logic          br_taken,
  input  logic [AW-1:0] br_target,
  input  logic          ds_enable,
  input  logic          fault_fetch,
  input  logic          fault_exec,
  input  logic          eret,
  output logic [AW-1:0] fetch_pc,
  output logic [1:0]    slot_idx,
  output logic          exec_ok,
  output logic          annul,
  output logic          illegal_br,
  output logic          exc_take,
  output logic          in_handler,
  output logic [AW-1:0] sv_pc,
  output logic [1:0]    sv_idx,
  output logic          sv_taken,
  output logic [AW-1:0] sv_target
);

  localparam int STEP = 4;

  slot_t         cur_idx;
  logic          cur_taken;
  logic [AW-1:0] cur_target;
  logic          cur_last;
  slot_t         rs_idx;

  // Named internal events
  logic          in_slot;
  logic          slot_run;
  logic          branch_go;
  logic          slot_open;
  logic          slot_end;
  logic          eret_go;
  logic          adv;
  logic          bad_br;
  nx_sel_e       nx_sel;
  logic [AW-1:0] jump_pc;

  assign in_slot = (cur_idx != '0);

  generate
    if (NSLOT == 1) begin : g_one_slot
      assign slot_run = 1'b1;
    end else begin : g_multi_slot
      assign slot_run = slot_runs(cur_idx, cur_taken);
    end
  endgenerate

  assign exc_take   = inst_valid && (fault_fetch || fault_exec) && slot_run && !in_handler;
  assign eret_go    = inst_valid && eret && in_handler && slot_run;
  assign bad_br     = inst_valid && br_dec && in_slot && !exc_take && !eret_go;
  assign branch_go  = inst_valid && br_dec && !in_slot && !exc_take && !eret_go;
  assign slot_open  = branch_go && ds_enable;
  assign adv        = inst_valid && !exc_take && !eret_go;
  assign slot_end   = in_slot && cur_last && adv;

  assign exec_ok    = inst_valid && slot_run && !exc_take && !bad_br;
  assign annul      = inst_valid && !exc_take && (!slot_run || bad_br);
  assign illegal_br = bad_br;
  assign slot_idx   = cur_idx;

  assign jump_pc = in_slot ? cur_target : br_target;

  always_comb begin
    if (!inst_valid)                              nx_sel = NX_HOLD;
    else if (exc_take)                            nx_sel = NX_VEC;
    else if (eret_go)                             nx_sel = NX_RESUME;
    else if (branch_go && !ds_enable && br_taken) nx_sel = NX_JUMP;
    else if (slot_end && cur_taken)               nx_sel = NX_JUMP;
    else                                          nx_sel = NX_SEQ;
  end

  bds_pc_gen #(
    .AW(AW), .RESET_PC(RESET_PC), .EXC_VEC(EXC_VEC), .STEP(STEP)
  ) u_pc (
    .clk(clk), .rst_n(rst_n), .sel(nx_sel),
    .resume_pc(sv_pc), .jump_pc(jump_pc), .pc(fetch_pc)
  );

  assign rs_idx = slot_t'(sv_idx);

  bds_slot_tracker #(.AW(AW), .NSLOT(NSLOT)) u_slots (
    .clk(clk), .rst_n(rst_n), .adv(adv),
    .start(slot_open), .start_taken(br_taken), .start_target(br_target),
    .flush(exc_take), .restore(eret_go),
    .rs_idx(rs_idx), .rs_taken(sv_taken), .rs_target(sv_target),
    .idx(cur_idx), .taken(cur_taken), .target(cur_target), .last(cur_last)
  );

  slot_t sv_idx_w;

  bds_exc_ctx #(.AW(AW)) u_ctx (
    .clk(clk), .rst_n(rst_n), .cap(exc_take), .release_ctx(eret_go),
    .cap_pc(fetch_pc), .cap_idx(cur_idx), .cap_taken(cur_taken),
    .cap_target(cur_target), .busy(in_handler),
    .sv_pc(sv_pc), .sv_idx(sv_idx_w), .sv_taken(sv_taken), .sv_target(sv_target)
  );

  assign sv_idx = sv_idx_w;

endmodule

// File: rtl/bds_sequencer_chk.sv
module bds_sequencer_chk #(
  parameter int            AW      = 32,
  parameter int            NSLOT   = 3,
  parameter logic [AW-1:0] EXC_VEC = 'h80
) (
  input logic          clk,
  input logic          rst_n,
  input logic          inst_valid,
  input logic [AW-1:0] fetch_pc,
  input logic [1:0]    slot_idx,
  input logic          exec_ok,
  input logic          annul,
  input logic          illegal_br,
  input logic          exc_take,
  input logic          in_handler,
  input logic          slot_end,
  input logic          cur_taken,
  input logic [AW-1:0] cur_target,
  input logic          eret_go,
  input logic [AW-1:0] sv_pc
);

  AST_EXEC_ANNUL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(exec_ok && annul)); // R4

  AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    slot_idx <= 2'(NSLOT)); // R3

  AST_SLOT1_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    (inst_valid && slot_idx == 2'd1) |-> (exec_ok || exc_take || illegal_br)); // R3

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !inst_valid |=> $stable(fetch_pc)); // R2

  AST_END_TO_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_end && cur_taken) |=> (fetch_pc == $past(cur_target))); // R5

  AST_ILLEGAL_ANNULS: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_br |-> (annul && !exec_ok)); // R7

  AST_EXC_TO_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take |=> (fetch_pc == EXC_VEC && in_handler)); // R8

  AST_EXC_NO_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take |-> !exec_ok); // R8

  AST_HANDLER_NO_EXC: assert property (@(posedge clk) disable iff (!rst_n)
    in_handler |-> !exc_take); // R9

  AST_ERET_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
    eret_go |=> (fetch_pc == $past(sv_pc) && !in_handler)); // R10

endmodule

bind bds_sequencer bds_sequencer_chk #(.AW(AW), .NSLOT(NSLOT), .EXC_VEC(EXC_VEC)) u_chk (
  .clk(clk), .rst_n(rst_n), .inst_valid(inst_valid), .fetch_pc(fetch_pc),
  .slot_idx(slot_idx), .exec_ok(exec_ok), .annul(annul), .illegal_br(illegal_br),
  .exc_take(exc_take), .in_handler(in_handler), .slot_end(slot_end),
  .cur_taken(cur_taken), .cur_target(cur_target), .eret_go(eret_go), .sv_pc(sv_pc)
);

// File: tb/bds_sequencer_test.sv
module bds_sequencer_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        inst_valid, br_dec, br_taken, ds_enable, fault_fetch, fault_exec, eret;
  logic [31:0] br_target;
  logic [31:0] fetch_pc, sv_pc, sv_target;
  logic [1:0]  slot_idx, sv_idx;
  logic        exec_ok, annul, illegal_br, exc_take, in_handler, sv_taken;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bds_sequencer #(.AW(32), .NSLOT(3), .RESET_PC(32'h100), .EXC_VEC(32'h80)) uut (
    .clk(clk), .rst_n(rst_n), .inst_valid(inst_valid), .br_dec(br_dec),
    .br_taken(br_taken), .br_target(br_target), .ds_enable(ds_enable),
    .fault_fetch(fault_fetch), .fault_exec(fault_exec), .eret(eret),
    .fetch_pc(fetch_pc), .slot_idx(slot_idx), .exec_ok(exec_ok), .annul(annul),
    .illegal_br(illegal_br), .exc_take(exc_take), .in_handler(in_handler),
    .sv_pc(sv_pc), .sv_idx(sv_idx), .sv_taken(sv_taken), .sv_target(sv_target)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Drive one token at the falling edge, then settle before the rising edge.
  task automatic drive(input logic v, input logic br, input logic tk, input logic [31:0] tgt,
                       input logic en, input logic ff, input logic fe, input logic er);
    @(negedge clk);
    inst_valid = v; br_dec = br; br_taken = tk; br_target = tgt;
    ds_enable = en; fault_fetch = ff; fault_exec = fe; eret = er;
    #1;
  endtask

  task automatic issue(input string req, input logic br, input logic tk, input logic [31:0] tgt,
                       input logic en, input logic ff, input logic fe, input logic er,
                       input logic [31:0] pc_e, input int idx_e, input logic ex_e, input logic an_e);
    drive(1'b1, br, tk, tgt, en, ff, fe, er);
    chk(req, "fetch_pc", fetch_pc, pc_e);
    chk(req, "slot_idx", {30'd0, slot_idx}, idx_e);
    chk(req, "exec_ok", {31'd0, exec_ok}, {31'd0, ex_e});
    chk(req, "annul", {31'd0, annul}, {31'd0, an_e});
  endtask

  task automatic plain(input string req, input logic [31:0] pc_e, input int idx_e,
                       input logic ex_e, input logic an_e);
    issue(req, 0, 0, 0, 1, 0, 0, 0, pc_e, idx_e, ex_e, an_e);
  endtask

  task automatic t_reset;
    chk("R1", "fetch_pc", fetch_pc, 32'h100);
    chk("R1", "slot_idx", {30'd0, slot_idx}, 0);
    chk("R1", "in_handler", {31'd0, in_handler}, 0);
    chk("R1", "sv_pc", sv_pc, 0);
    chk("R1", "sv_ctx", {29'd0, sv_idx, sv_taken} | sv_target, 0);
  endtask

  task automatic t_sequential;
    plain("R2", 32'h100, 0, 1, 0);
    drive(0, 0, 0, 0, 1, 0, 0, 0);
    chk("R2", "idle fetch_pc", fetch_pc, 32'h104);
    chk("R2", "idle exec/annul", {30'd0, exec_ok, annul}, 0);
    drive(0, 0, 0, 0, 1, 0, 0, 0);
    chk("R2", "hold fetch_pc", fetch_pc, 32'h104);
    plain("R2", 32'h104, 0, 1, 0);
  endtask

  task automatic t_taken;
    issue("R3", 1, 1, 32'h400, 1, 0, 0, 0, 32'h108, 0, 1, 0);
    plain("R3", 32'h10C, 1, 1, 0);
    plain("R4", 32'h110, 2, 1, 0);
    plain("R4", 32'h114, 3, 1, 0);
    plain("R5", 32'h400, 0, 1, 0);
  endtask

  task automatic t_untaken;
    issue("R3", 1, 0, 32'h800, 1, 0, 0, 0, 32'h404, 0, 1, 0);
    plain("R3", 32'h408, 1, 1, 0);
    plain("R4", 32'h40C, 2, 0, 1);
    plain("R4", 32'h410, 3, 0, 1);
    plain("R5", 32'h414, 0, 1, 0);
  endtask

  task automatic t_disabled;
    issue("R6", 1, 1, 32'h200, 0, 0, 0, 0, 32'h418, 0, 1, 0);
    issue("R6", 1, 0, 32'h900, 0, 0, 0, 0, 32'h200, 0, 1, 0);
    issue("R6", 1, 1, 32'h300, 1, 0, 0, 0, 32'h204, 0, 1, 0);
    issue("R6", 0, 0, 0, 0, 0, 0, 0, 32'h208, 1, 1, 0);
    issue("R6", 0, 0, 0, 0, 0, 0, 0, 32'h20C, 2, 1, 0);
    issue("R6", 0, 0, 0, 0, 0, 0, 0, 32'h210, 3, 1, 0);
    plain("R6", 32'h300, 0, 1, 0);
  endtask

  task automatic t_illegal;
    issue("R7", 1, 1, 32'h500, 1, 0, 0, 0, 32'h304, 0, 1, 0);
    issue("R7", 1, 1, 32'h900, 1, 0, 0, 0, 32'h308, 1, 0, 1);
    chk("R7", "illegal_br", {31'd0, illegal_br}, 1);
    plain("R7", 32'h30C, 2, 1, 0);
    chk("R7", "illegal_br clear", {31'd0, illegal_br}, 0);
    plain("R7", 32'h310, 3, 1, 0);
    plain("R7", 32'h500, 0, 1, 0);
  endtask

  task automatic t_slot_exception;
    issue("R8", 1, 1, 32'h600, 1, 0, 0, 0, 32'h504, 0, 1, 0);
    plain("R8", 32'h508, 1, 1, 0);
    issue("R8", 0, 0, 0, 1, 0, 1, 0, 32'h50C, 2, 0, 0);
    chk("R8", "exc_take", {31'd0, exc_take}, 1);
    issue("R9", 0, 0, 0, 1, 1, 0, 0, 32'h80, 0, 1, 0);
    chk("R9", "exc in handler", {31'd0, exc_take}, 0);
    chk("R8", "in_handler", {31'd0, in_handler}, 1);
    chk("R8", "sv_pc", sv_pc, 32'h50C);
    chk("R8", "sv_idx", {30'd0, sv_idx}, 2);
    chk("R8", "sv_taken", {31'd0, sv_taken}, 1);
    chk("R8", "sv_target", sv_target, 32'h600);
    issue("R10", 0, 0, 0, 1, 0, 0, 1, 32'h84, 0, 1, 0);
    plain("R10", 32'h50C, 2, 1, 0);
    chk("R10", "in_handler", {31'd0, in_handler}, 0);
    plain("R10", 32'h510, 3, 1, 0);
    plain("R10", 32'h600, 0, 1, 0);
  endtask

  task automatic t_annul_fault;
    issue("R8", 1, 0, 32'hA00, 1, 0, 0, 0, 32'h604, 0, 1, 0);
    issue("R8", 0, 0, 0, 1, 1, 0, 0, 32'h608, 1, 0, 0);
    chk("R8", "fetch fault exc_take", {31'd0, exc_take}, 1);
    issue("R10", 0, 0, 0, 1, 0, 0, 1, 32'h80, 0, 1, 0);
    chk("R8", "sv_idx", {30'd0, sv_idx}, 1);
    chk("R8", "sv_taken", {31'd0, sv_taken}, 0);
    chk("R8", "sv_target", sv_target, 32'hA00);
    plain("R10", 32'h608, 1, 1, 0);
    issue("R9", 0, 0, 0, 1, 1, 0, 0, 32'h60C, 2, 0, 1);
    chk("R9", "annulled fault", {31'd0, exc_take}, 0);
    plain("R9", 32'h610, 3, 0, 1);
    plain("R5", 32'h614, 0, 1, 0);
  endtask

  task automatic t_plain_exception;
    issue("R8", 0, 0, 0, 1, 0, 1, 0, 32'h618, 0, 0, 0);
    chk("R8", "exc_take", {31'd0, exc_take}, 1);
    issue("R10", 0, 0, 0, 1, 0, 0, 1, 32'h80, 0, 1, 0);
    chk("R8", "sv_pc", sv_pc, 32'h618);
    chk("R8", "sv_idx/taken", {29'd0, sv_idx, sv_taken}, 0);
    chk("R8", "sv_target", sv_target, 0);
    plain("R10", 32'h618, 0, 1, 0);
    plain("R2", 32'h61C, 0, 1, 0);
  endtask

  initial begin
    rst_n = 0; inst_valid = 0; br_dec = 0; br_taken = 0; br_target = 0;
    ds_enable = 1; fault_fetch = 0; fault_exec = 0; eret = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset;
    rst_n = 1;
    t_sequential;
    t_taken;
    t_untaken;
    t_disabled;
    t_illegal;
    t_slot_exception;
    t_annul_fault;
    t_plain_exception;
    drive(0, 0, 0, 0, 1, 0, 0, 0);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      nchk++;
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

endmodule